// File: doc/BRIEF.md
# Pipelined Synchronous Burst SRAM Controller

This block is a cycle-level model of a single-clock synchronous SRAM with a pipelined read path, per-lane write control and a short address burst generator. Each rising edge samples two address strobes, an advance input, three chip enables and the write controls. From these it decides whether the edge starts a new access, continues a burst, suspends a burst or does nothing. The storage is a reduced-depth array of 36-bit words, and each word is split into four 9-bit lanes.

Reads leave a registered data word one edge after the edge that sampled the address. A driver-enable output tells the surrounding pad logic when the data should be driven. It follows the output-enable pin asynchronously, and any write command forces it off. A sleep input puts the array to rest after a fixed settling count, and waking it takes the same count.

Top module: `sbc_sram_ctl`

## Requirements
- R1: A write command exists when `all_wr_n` is 0, or when `lane_wr_n` is 0 and at least one bit of `lane_en_n` is 0. If `lane_wr_n` is 0 and `lane_en_n` is 4'hF, the cycle is a read and no lane changes.
- R2: When `all_wr_n` is 0, a write updates all four lanes, whatever `lane_en_n` and `lane_wr_n` hold.
- R3: When `all_wr_n` is 1 and `lane_wr_n` is 0, only the lanes whose `lane_en_n` bit is 0 are written. Bit i controls word bits [9i+8:9i], and the other lanes keep their contents.
- R4: An edge with `proc_strobe_n` at 0 is always a read of `addr`, and the write controls have no effect on that edge. `proc_strobe_n` has priority over `ctrl_strobe_n`.
- R5: The block is selected when `sel_n`=0, `sel_hi`=1 and `sel_lo_n`=0. The enables are sampled only on edges where a strobe is low, and the last result is kept on other edges. A deselected block does no access and leaves `drive_en` at 0.
- R6: Read data for an address sampled at edge k appears on `rdata` after edge k+1.
- R7: On an edge with no strobe, `adv_n`=0 moves to the next burst address and `adv_n`=1 repeats the current address, for reads and writes alike. The two low address bits run through four steps and wrap. With `burst_interleave`=0 the step k address is base+k mod 4. With `burst_interleave`=1 it is base XOR k.
- R8: A read that is sampled on the edge after a write to the same address returns the newly written word.
- R9: `drive_en` is 1 only while a read result is held and `out_en_n` is 0. It follows `out_en_n` without a clock. A write command sampled with no processor strobe forces `drive_en` to 0 for the following cycle.
- R10: `asleep` rises on the fourth consecutive edge that samples `sleep_req`=1, and falls on the fourth consecutive edge that samples it at 0. While `asleep` is 1, no access is accepted, `drive_en` is 0 and the array contents are kept.
- R11: After reset, `rdata` is 0, `drive_en` is 0, `asleep` is 0 and the block is deselected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W | Word address, loaded on strobe edges |
| sel_n | input | 1 | Primary enable, active low |
| sel_hi | input | 1 | Second enable, active high |
| sel_lo_n | input | 1 | Third enable, active low |
| proc_strobe_n | input | 1 | Address strobe that always starts a read |
| ctrl_strobe_n | input | 1 | Address strobe that starts a read or a write |
| adv_n | input | 1 | Burst advance, active low |
| all_wr_n | input | 1 | Whole-word write, active low |
| lane_wr_n | input | 1 | Lane-write qualifier, active low |
| lane_en_n | input | LANES | Per-lane write enables, active low |
| wdata | input | LANES*LANE_W | Write data |
| out_en_n | input | 1 | Asynchronous output enable, active low |
| burst_interleave | input | 1 | Burst order: 0 linear, 1 interleaved |
| sleep_req | input | 1 | Sleep request, active high |
| rdata | output | LANES*LANE_W | Registered read data |
| drive_en | output | 1 | Data driver enable for pad logic |
| asleep | output | 1 | Sleep state |

## Verification
The write decoder is tested with random mixes of whole-word, lane and empty-lane writes through the control strobe. Each is read back, which separates lane masking from whole-word writes and from null writes. Random write controls are also applied on processor-strobe reads, to show that the processor strobe cannot write. Directed bursts from an unaligned base in both orders separate the linear sequence from the interleaved one and show the wrap. Suspended reads and writes show that `adv_n`=1 holds the address. Bad enable patterns, write-to-read back-to-back, output-enable toggling and a full sleep cycle with a blocked write attempt cover the select, pass-through, driver and sleep paths.

// File: rtl/sbc_pkg.sv
package sbc_pkg;
   typedef enum logic {
      ORDER_LINEAR     = 1'b0,
      ORDER_INTERLEAVE = 1'b1
   } burst_order_e;

   localparam int LANE_BITS_DEFAULT = 9;
endpackage

// File: rtl/sbc_burst_seq.sv
module sbc_burst_seq #(
   parameter int BURST_W        = 2,
   parameter bit HAS_INTERLEAVE = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               load,
   input  logic               step,
   input  logic               en,
   input  logic [BURST_W-1:0] start,
   input  logic               interleave,
   output logic [BURST_W-1:0] lo
);
   import sbc_pkg::*;

   logic [BURST_W-1:0] base_q, cnt_q, cnt_nxt, base_sel;

   assign cnt_nxt  = load ? '0 : cnt_q + BURST_W'(step);
   assign base_sel = load ? start : base_q;

   generate
      if (HAS_INTERLEAVE) begin : g_both
         burst_order_e order;
         assign order = burst_order_e'(interleave);
         assign lo = (order == ORDER_INTERLEAVE) ? (base_sel ^ cnt_nxt)
                                                 : (base_sel + cnt_nxt);
      end else begin : g_linear
         logic unused_order;
         assign unused_order = interleave;
         assign lo = base_sel + cnt_nxt;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_q <= '0;
         cnt_q  <= '0;
      end else if (en) begin
         cnt_q <= cnt_nxt;
         if (load) base_q <= start;
      end
   end
endmodule

// File: rtl/sbc_sleep_ctl.sv
module sbc_sleep_ctl #(
   parameter int SLEEP_CYC = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic req,
   output logic asleep
);
   localparam int CW = (SLEEP_CYC < 2) ? 1 : $clog2(SLEEP_CYC);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         asleep <= 1'b0;
      end else if (req != asleep) begin
         if (cnt_q == CW'(SLEEP_CYC - 1)) begin
            asleep <= req;
            cnt_q  <= '0;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end else begin
         cnt_q <= '0;
      end
   end
endmodule

// File: rtl/sbc_lane_mem.sv
module sbc_lane_mem #(
   parameter int ADDR_W = 6,
   parameter int LANES  = 4,
   parameter int LANE_W = 9
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [LANES-1:0]        we,
   input  logic [ADDR_W-1:0]       waddr,
   input  logic [LANES*LANE_W-1:0] wdata,
   input  logic                    rd_en,
   input  logic [ADDR_W-1:0]       raddr,
   output logic [LANES*LANE_W-1:0] rdata
);
   localparam int DEPTH = 1 << ADDR_W;

   generate
      for (genvar g = 0; g < LANES; g++) begin : g_lane
         logic [LANE_W-1:0] mem [DEPTH];
         logic [LANE_W-1:0] rd_q;

         always_ff @(posedge clk) begin
            if (we[g]) mem[waddr] <= wdata[g*LANE_W +: LANE_W];
         end

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     rd_q <= '0;
            else if (rd_en) rd_q <= mem[raddr];
         end

         assign rdata[g*LANE_W +: LANE_W] = rd_q;
      end
   endgenerate
endmodule

// File: rtl/sbc_sram_ctl.sv
module sbc_sram_ctl #(
   parameter int ADDR_W         = 6,
   parameter int LANES          = 4,
   parameter int LANE_W         = sbc_pkg::LANE_BITS_DEFAULT,
   parameter int BURST_W        = 2,
   parameter int SLEEP_CYC      = 4,
   parameter bit HAS_INTERLEAVE = 1'b1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [ADDR_W-1:0]       addr,
   input  logic                    sel_n,
   input  logic                    sel_hi,
   input  logic                    sel_lo_n,
   input  logic                    proc_strobe_n,
   input  logic                    ctrl_strobe_n,
   input  logic                    adv_n,
   input  logic                    all_wr_n,
   input  logic                    lane_wr_n,
   input  logic [LANES-1:0]        lane_en_n,
   input  logic [LANES*LANE_W-1:0] wdata,
   input  logic                    out_en_n,
   input  logic                    burst_interleave,
   input  logic                    sleep_req,
   output logic [LANES*LANE_W-1:0] rdata,
   output logic                    drive_en,
   output logic                    asleep
);
   localparam int HI_W = ADDR_W - BURST_W;

   generate
      if (BURST_W < 1 || HI_W < 1) begin : g_bad_burst
         $error("sbc_sram_ctl: BURST_W must be at least 1 and below ADDR_W");
      end
      if (LANES < 1 || LANE_W < 1) begin : g_bad_lane
         $error("sbc_sram_ctl: LANES and LANE_W must be positive");
      end
      if (SLEEP_CYC < 1) begin : g_bad_sleep
         $error("sbc_sram_ctl: SLEEP_CYC must be positive");
      end
   endgenerate

   logic              sel_ok, strobe, wr_cmd, awake, accept;
   logic              do_write, do_read, load, sel_q;
   logic [LANES-1:0]  lane_req, lane_we;
   logic [HI_W-1:0]   base_hi_q;
   logic [BURST_W-1:0] burst_lo;
   logic [ADDR_W-1:0] acc_addr, rd_addr_q;
   logic              rd_pend_q, out_valid_q;

   assign sel_ok = !sel_n && sel_hi && !sel_lo_n;
   assign strobe = !proc_strobe_n || !ctrl_strobe_n;
   assign wr_cmd = !all_wr_n || (!lane_wr_n && !(&lane_en_n));
   assign awake  = !asleep;

   assign lane_req = !all_wr_n ? '1 : (lane_wr_n ? '0 : ~lane_en_n);

   assign accept   = awake && (strobe ? sel_ok : sel_q);
   assign load     = awake && strobe && sel_ok;
   assign do_write = accept && proc_strobe_n && wr_cmd;
   assign do_read  = accept && !do_write;
   assign lane_we  = do_write ? lane_req : '0;

   assign acc_addr = {(strobe ? addr[ADDR_W-1:BURST_W] : base_hi_q), burst_lo};

   sbc_burst_seq #(
      .BURST_W        (BURST_W),
      .HAS_INTERLEAVE (HAS_INTERLEAVE)
   ) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .load       (load),
      .step       (!adv_n && !strobe),
      .en         (accept),
      .start      (addr[BURST_W-1:0]),
      .interleave (burst_interleave),
      .lo         (burst_lo)
   );

   sbc_sleep_ctl #(
      .SLEEP_CYC (SLEEP_CYC)
   ) u_sleep (
      .clk    (clk),
      .rst_n  (rst_n),
      .req    (sleep_req),
      .asleep (asleep)
   );

   sbc_lane_mem #(
      .ADDR_W (ADDR_W),
      .LANES  (LANES),
      .LANE_W (LANE_W)
   ) u_mem (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (lane_we),
      .waddr (acc_addr),
      .wdata (wdata),
      .rd_en (rd_pend_q),
      .raddr (rd_addr_q),
      .rdata (rdata)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_q       <= 1'b0;
         base_hi_q   <= '0;
         rd_pend_q   <= 1'b0;
         rd_addr_q   <= '0;
         out_valid_q <= 1'b0;
      end else begin
         if (awake && strobe) sel_q <= sel_ok;
         if (load) base_hi_q <= addr[ADDR_W-1:BURST_W];
         rd_pend_q   <= do_read;
         rd_addr_q   <= acc_addr;
         out_valid_q <= rd_pend_q && !(awake && proc_strobe_n && wr_cmd);
      end
   end

   assign drive_en = out_valid_q && !out_en_n && !asleep;
endmodule

// File: rtl/sbc_sram_ctl_chk.sv
module sbc_sram_ctl_chk #(
   parameter int LANES = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             sel_n,
   input logic             sel_hi,
   input logic             sel_lo_n,
   input logic             proc_strobe_n,
   input logic             ctrl_strobe_n,
   input logic             all_wr_n,
   input logic             lane_wr_n,
   input logic [LANES-1:0] lane_en_n,
   input logic             out_en_n,
   input logic             sleep_req,
   input logic             drive_en,
   input logic             asleep
);
   logic c_sel, c_strobe, c_wr;
   assign c_sel    = !sel_n && sel_hi && !sel_lo_n;
   assign c_strobe = !proc_strobe_n || !ctrl_strobe_n;
   assign c_wr     = !all_wr_n || (!lane_wr_n && (lane_en_n != '1));

   AST_READ_PIPE: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n, 2) && $past(!proc_strobe_n && c_sel && !asleep, 2)
       && !$past(proc_strobe_n && c_wr && !asleep, 1))
      |-> (drive_en || out_en_n || asleep)); // R6

   AST_WRITE_MUTES_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
      $past(proc_strobe_n && c_wr && !asleep) |-> !drive_en); // R9

   AST_DESEL_MUTE: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n, 2) && $past(c_strobe && !c_sel && !asleep, 2)) |-> !drive_en); // R5

   AST_SLEEP_ENTER: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(asleep) |-> ($past(sleep_req, 1) && $past(sleep_req, 2)
                         && $past(sleep_req, 3) && $past(sleep_req, 4))); // R10

   AST_SLEEP_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(asleep) |-> (!$past(sleep_req, 1) && !$past(sleep_req, 2)
                         && !$past(sleep_req, 3) && !$past(sleep_req, 4))); // R10

   AST_ASLEEP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      asleep |-> !drive_en); // R10
endmodule

bind sbc_sram_ctl sbc_sram_ctl_chk #(.LANES(LANES)) u_chk (.*);

// File: tb/sbc_sram_ctl_tb.sv
module sbc_sram_ctl_tb;
   localparam int AW = 6;
   localparam int NW = 1 << AW;
   localparam int DW = 36;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] addr = '0;
   logic          sel_n = 1'b0, sel_hi = 1'b1, sel_lo_n = 1'b0;
   logic          proc_strobe_n = 1'b1, ctrl_strobe_n = 1'b1, adv_n = 1'b1;
   logic          all_wr_n = 1'b1, lane_wr_n = 1'b1;
   logic [3:0]    lane_en_n = 4'hF;
   logic [DW-1:0] wdata = '0;
   logic          out_en_n = 1'b0, burst_interleave = 1'b0, sleep_req = 1'b0;
   logic [DW-1:0] rdata;
   logic          drive_en, asleep;

   logic [DW-1:0] ref_mem [NW];
   int n_checks = 0, n_fails = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   sbc_sram_ctl u_dut (
      .clk(clk), .rst_n(rst_n), .addr(addr), .sel_n(sel_n), .sel_hi(sel_hi),
      .sel_lo_n(sel_lo_n), .proc_strobe_n(proc_strobe_n),
      .ctrl_strobe_n(ctrl_strobe_n), .adv_n(adv_n), .all_wr_n(all_wr_n),
      .lane_wr_n(lane_wr_n), .lane_en_n(lane_en_n), .wdata(wdata),
      .out_en_n(out_en_n), .burst_interleave(burst_interleave),
      .sleep_req(sleep_req), .rdata(rdata), .drive_en(drive_en), .asleep(asleep)
   );

   function automatic logic [DW-1:0] merge(input logic [DW-1:0] old_w,
      input logic [DW-1:0] new_w, input logic gw, input logic bw, input logic [3:0] be);
      logic [DW-1:0] res = old_w;
      if (!gw) return new_w;
      if (!bw)
         for (int i = 0; i < 4; i++)
            if (!be[i]) res[i*9 +: 9] = new_w[i*9 +: 9];
      return res;
   endfunction

   function automatic logic [1:0] step_lo(input logic inter, input logic [1:0] base,
                                          input int k);
      return inter ? (base ^ 2'(k)) : (base + 2'(k));
   endfunction

   function automatic logic [DW-1:0] rnd_word();
      logic [63:0] v = {$urandom, $urandom};
      return v[DW-1:0];
   endfunction

   task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic cyc(input logic p, input logic c, input logic av, input logic gw,
                      input logic bw, input logic [3:0] be, input logic [AW-1:0] a,
                      input logic [DW-1:0] d);
      proc_strobe_n = p; ctrl_strobe_n = c; adv_n = av; all_wr_n = gw;
      lane_wr_n = bw; lane_en_n = be; addr = a; wdata = d;
      @(posedge clk);
      #1;
   endtask

   task automatic idle();
      cyc(1, 1, 1, 1, 1, 4'hF, addr, '0);
   endtask

   task automatic advance();
      cyc(1, 1, 0, 1, 1, 4'hF, addr, '0);
   endtask

   task automatic read_back(input string req, input logic [AW-1:0] a);
      cyc(0, 1, 1, 1, 1, 4'hF, a, '0);
      idle();
      check(req, rdata, ref_mem[a]);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_checks++; n_fails++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd2024));
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      // R11 reset state
      check("R11 rdata", rdata, '0);
      check("R11 drive_en", {35'd0, drive_en}, 36'd0);
      check("R11 asleep", {35'd0, asleep}, 36'd0);
      idle(); idle();
      check("R11 deselected", {35'd0, drive_en}, 36'd0);

      // fill array with whole-word writes (R2)
      for (int a = 0; a < NW; a++) begin
         logic [DW-1:0] d = rnd_word();
         cyc(1, 0, 1, 0, 1, 4'hF, AW'(a), d);
         ref_mem[a] = d;
      end
      idle();

      // constrained random mix
      for (int it = 0; it < 400; it++) begin
         logic [AW-1:0] a = AW'($urandom % NW);
         logic gw = ($urandom % 4) != 0;
         logic bw = 1'($urandom);
         logic [3:0] be = 4'($urandom);
         logic [DW-1:0] d = rnd_word();
         if ($urandom % 2) begin
            cyc(1, 0, 1, gw, bw, be, a, d);
            if (!gw || (!bw && be != 4'hF)) ref_mem[a] = merge(ref_mem[a], d, gw, bw, be);
            idle();
         end else begin
            // R4: write controls ignored on processor strobe edge
            cyc(0, 1, 1, gw, bw, be, a, d);
            idle();
            check("R4/R6 random read", rdata, ref_mem[a]);
            check("R9 drive after read", {35'd0, drive_en}, 36'd1);
         end
      end
      read_back("R3 lane write readback", 6'd4);

      // R1: lane qualifier low with no lane enabled is a read
      cyc(1, 0, 1, 1, 0, 4'hF, 6'd2, rnd_word());
      idle();
      check("R1 null lane write", rdata, ref_mem[2]);

      // R3: single lane
      begin
         logic [DW-1:0] d = rnd_word();
         cyc(1, 0, 1, 1, 0, 4'b1011, 6'd6, d);
         ref_mem[6] = merge(ref_mem[6], d, 1, 0, 4'b1011);
         idle();
         read_back("R3 lane2 only", 6'd6);
      end

      // R4: processor strobe with global write held low does not write
      cyc(0, 1, 1, 0, 0, 4'h0, 6'd8, ~ref_mem[8]);
      idle();
      read_back("R4 strobe read no write", 6'd8);

      // R7 bursts in both orders from an unaligned base
      for (int m = 0; m < 2; m++) begin
         burst_interleave = 1'(m);
         cyc(0, 1, 1, 1, 1, 4'hF, 6'h11, '0);
         for (int k = 1; k <= 4; k++) begin
            advance();
            check("R7 burst step", rdata, ref_mem[{4'h4, step_lo(1'(m), 2'b01, k - 1)}]);
         end
         idle();
         check("R7 burst wrap", rdata, ref_mem[6'h11]);
      end
      burst_interleave = 1'b0;

      // R7 suspend on reads
      cyc(0, 1, 1, 1, 1, 4'hF, 6'h12, '0);
      idle();
      check("R7 suspend first", rdata, ref_mem[6'h12]);
      advance();
      check("R7 suspend held", rdata, ref_mem[6'h12]);
      idle();
      check("R7 after advance", rdata, ref_mem[6'h13]);

      // R7 burst write with advance and suspend
      begin
         logic [DW-1:0] d0 = rnd_word(), d1 = rnd_word(), d2 = rnd_word();
         cyc(1, 0, 1, 0, 1, 4'hF, 6'h20, d0);
         cyc(1, 1, 0, 0, 1, 4'hF, 6'h20, d1);
         cyc(1, 1, 1, 0, 1, 4'hF, 6'h20, d2);
         ref_mem[6'h20] = d0; ref_mem[6'h21] = d2;
         idle();
         read_back("R7 burst write base", 6'h20);
         read_back("R7 suspended write", 6'h21);
      end

      // R8 write then immediate read
      begin
         logic [DW-1:0] d = rnd_word();
         cyc(1, 0, 1, 0, 1, 4'hF, 6'd9, d);
         ref_mem[9] = d;
         cyc(0, 1, 1, 1, 1, 4'hF, 6'd9, '0);
         idle();
         check("R8 pass-through", rdata, d);
      end

      // R5 each enable deselects; strobed write ignored
      for (int e = 0; e < 3; e++) begin
         sel_n = (e == 0); sel_hi = (e != 1); sel_lo_n = (e == 2);
         cyc(1, 0, 1, 0, 1, 4'hF, 6'd5, ~ref_mem[5]);
         sel_n = 1'b0; sel_hi = 1'b1; sel_lo_n = 1'b0;
         idle();
         check("R5 deselected drive", {35'd0, drive_en}, 36'd0);
         idle();
         check("R5 deselected hold", {35'd0, drive_en}, 36'd0);
         read_back("R5 deselected no write", 6'd5);
      end

      // R5 enables ignored without strobe
      cyc(0, 1, 1, 1, 1, 4'hF, 6'd7, '0);
      sel_n = 1'b1; sel_hi = 1'b0;
      idle(); idle();
      check("R5 selection held", rdata, ref_mem[7]);
      check("R5 selection held drive", {35'd0, drive_en}, 36'd1);
      sel_n = 1'b0; sel_hi = 1'b1;

      // R9 output enable and write muting
      out_en_n = 1'b1; #1;
      check("R9 oe high", {35'd0, drive_en}, 36'd0);
      out_en_n = 1'b0; #1;
      check("R9 oe low", {35'd0, drive_en}, 36'd1);
      begin
         logic [DW-1:0] d = rnd_word();
         cyc(1, 1, 1, 0, 1, 4'hF, 6'd7, d);
         ref_mem[7] = d;
         check("R9 write mutes drive", {35'd0, drive_en}, 36'd0);
         idle();
         check("R9 still muted", {35'd0, drive_en}, 36'd0);
         idle();
         check("R9/R8 continued read", rdata, d);
      end

      // R10 sleep entry, blocked access, exit
      cyc(0, 1, 1, 1, 1, 4'hF, 6'd3, '0);
      idle();
      sleep_req = 1'b1;
      for (int i = 1; i <= 3; i++) begin
         idle();
         check("R10 entry delay", {35'd0, asleep}, 36'd0);
      end
      idle();
      check("R10 asleep", {35'd0, asleep}, 36'd1);
      check("R10 asleep drive", {35'd0, drive_en}, 36'd0);
      cyc(1, 0, 1, 0, 1, 4'hF, 6'd3, ~ref_mem[3]);
      idle();
      sleep_req = 1'b0;
      for (int i = 1; i <= 3; i++) begin
         idle();
         check("R10 exit delay", {35'd0, asleep}, 36'd1);
      end
      idle();
      check("R10 awake", {35'd0, asleep}, 36'd0);
      read_back("R10 contents kept", 6'd3);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
   end
endmodule